// File: doc/BRIEF.md
# Multi-phase input edge timestamper

This block watches one digital input and produces one record for each rising edge it sees. A record holds a running event index and a timestamp. The upper part of the timestamp is a free-running coarse count of main-clock periods. The two low bits say in which quarter of that period the input was first seen high. The input is sampled four times per main period: on the rising edge of the main clock, on the rising edge of a quarter-period-shifted copy of that clock, on the falling edge of the main clock, and on the falling edge of the shifted copy. With a 400 MHz main clock this gives a step of about 0.625 ns instead of 2.5 ns.

Each of the four samples goes through a two-flop synchroniser in the main clock domain. The four samples of one period form a thermometer-style pattern. A small decoder turns that pattern into the fine field and finds the edge. Records leave on a valid/ready stream, which feeds a downstream store where the timestamps are averaged or line-fitted. That store holds sequences of several million records per second.

A single holding register sits at the output. If an edge arrives while that register is full and the consumer is stalling, the record is lost and a sticky flag rises. The event index still advances, so the gap shows in the stored data. A synchronous clear zeroes the event index and the coarse counter in the same cycle. The coarse counter is 32 bits wide and wraps silently.

Top module: `edge_stamper`

## Requirements
- R1: Every rising edge of `sig_in` yields exactly one record, unless the record is dropped as in R6. Event indices start at 0 after reset and rise by one per detected edge.
- R2: `rec_stamp` is {coarse, fine}: `rec_stamp[33:2]` is the coarse count and `rec_stamp[1:0]` is the fine field. The coarse count is the index of the main-clock period in which the first high sample was taken. The period that begins at the k-th main rising edge after reset or clear has index k.
- R3: The four sample instants in a period are numbered 0 to 3: main rise, shifted rise, main fall, shifted fall. The fine field is the number of the first instant at which the input is seen high after a low sample. An edge that falls after instant 3 belongs to the next period, with fine 0.
- R4: `rec_valid` rises at the third main rising edge after the start of the period that holds the first high sample.
- R5: While `rec_valid` is high and `rec_ready` is low, `rec_valid`, `rec_event` and `rec_stamp` hold their values.
- R6: An edge detected while the holding register is full and `rec_ready` is low is dropped. It sets `rec_ovf`, which stays high until reset, and it still consumes one event index.
- R7: A one-cycle `clr` sets both the event index and the coarse count to zero. The next record has event 0 and a coarse value counted from the clear.
- R8: During and after reset, with no edges, `rec_valid` and `rec_ovf` are low.
- R9: Edges two main periods apart, each with a one-period high level, all produce records in order with no loss while `rec_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; also the clock of the record stream |
| clk_shift | input | 1 | Copy of `clk` delayed by a quarter period |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of event index and coarse count |
| sig_in | input | 1 | Asynchronous input being timed |
| rec_ready | input | 1 | Consumer accepts the record this cycle |
| rec_valid | output | 1 | A record is presented |
| rec_event | output | 16 | Event index of the presented record |
| rec_stamp | output | 34 | Coarse count above a 2-bit fine field |
| rec_ovf | output | 1 | Sticky flag: a record was lost |

## Verification
The checker assumes that `sig_in` stays high and stays low for at least one main period. Under that rule, each sampling window contains at most one rising edge, so the internal edge strobe never fires on two cycles in a row. The checker also takes `clk_shift` to be a quarter-period-delayed copy of `clk`. The bench changes `sig_in` only between sample instants, and every level it drives lasts at least one full main period. It moves `rec_ready` and `clr` just after a main rising edge.

// File: rtl/stamp_pkg.sv
`timescale 1ns/1ps
package stamp_pkg;
  // Sample points per main period: two clocks, two edges each (structural).
  localparam int unsigned NPHASE  = 4;
  localparam int unsigned FINE_W  = $clog2(NPHASE);
  // Cycles between a sampling window and the cycle in which it is decoded.
  localparam int unsigned WIN_LAG = 2;
endpackage

// File: rtl/phase_sampler.sv
`timescale 1ns/1ps
module phase_sampler
  import stamp_pkg::*;
(
  input  logic              clk,
  input  logic              clk_shift,
  input  logic              rst,
  input  logic              din,
  output logic [NPHASE-1:0] win
);
  logic [NPHASE-1:0] cap;
  logic [NPHASE-1:0] sync1;

  // One capture flop per sample point, ordered by time inside the period.
  for (genvar i = 0; i < NPHASE; i++) begin : g_ph
    logic cap_q;
    if (i == 0) begin : g_mr
      always_ff @(posedge clk) cap_q <= din;
    end else if (i == 1) begin : g_sr
      always_ff @(posedge clk_shift) cap_q <= din;
    end else if (i == 2) begin : g_mf
      always_ff @(negedge clk) cap_q <= din;
    end else begin : g_sf
      always_ff @(negedge clk_shift) cap_q <= din;
    end
    assign cap[i] = cap_q;
  end

  // Two-flop synchroniser into the main domain; the first stage snapshots
  // the window that just ended.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      win   <= '0;
    end else begin
      sync1 <= cap;
      win   <= sync1;
    end
  end
endmodule

// File: rtl/edge_finder.sv
`timescale 1ns/1ps
module edge_finder
  import stamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NPHASE-1:0] win,
  output logic              hit,
  output logic [FINE_W-1:0] fine
);
  logic              last_q;
  logic [NPHASE-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= win[NPHASE-1];
  end

  // A low-to-high step between consecutive samples, the first sample
  // compared against the last sample of the previous window.
  for (genvar i = 0; i < NPHASE; i++) begin : g_rise
    if (i == 0) begin : g_first
      assign rise[i] = win[i] & ~last_q;
    end else begin : g_rest
      assign rise[i] = win[i] & ~win[i-1];
    end
  end

  always_comb begin
    fine = '0;
    for (int i = NPHASE - 1; i >= 0; i--) begin
      if (rise[i]) fine = FINE_W'(i);
    end
  end

  assign hit = |rise;
endmodule

// File: rtl/record_holder.sv
`timescale 1ns/1ps
module record_holder
  import stamp_pkg::*;
#(
  parameter int unsigned EVT_W = 16,
  parameter int unsigned CRS_W = 32,
  localparam int unsigned STAMP_W = CRS_W + FINE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               hit,
  input  logic [FINE_W-1:0]  fine,
  input  logic [CRS_W-1:0]   coarse_now,
  input  logic               ready,
  output logic               valid,
  output logic [EVT_W-1:0]   evt_out,
  output logic [STAMP_W-1:0] stamp_out,
  output logic               ovf
);
  logic [EVT_W-1:0] evt_cnt;
  logic             room;

  assign room = ~valid | ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      evt_out   <= '0;
      stamp_out <= '0;
      ovf       <= 1'b0;
      evt_cnt   <= '0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (hit) begin
        if (room) begin
          valid     <= 1'b1;
          evt_out   <= evt_cnt;
          stamp_out <= {coarse_now - CRS_W'(WIN_LAG), fine};
        end else begin
          ovf <= 1'b1;
        end
        evt_cnt <= evt_cnt + 1'b1;
      end
      if (clr) evt_cnt <= '0;
    end
  end
endmodule

// File: rtl/edge_stamper.sv
`timescale 1ns/1ps
module edge_stamper
  import stamp_pkg::*;
#(
  parameter int unsigned EVT_W = 16,
  parameter int unsigned CRS_W = 32,
  localparam int unsigned STAMP_W = CRS_W + FINE_W
) (
  input  logic               clk,
  input  logic               clk_shift,
  input  logic               rst,
  input  logic               clr,
  input  logic               sig_in,
  input  logic               rec_ready,
  output logic               rec_valid,
  output logic [EVT_W-1:0]   rec_event,
  output logic [STAMP_W-1:0] rec_stamp,
  output logic               rec_ovf
);
  logic [NPHASE-1:0] win;
  logic              hit;
  logic [FINE_W-1:0] fine;
  logic [CRS_W-1:0]  coarse;

  always_ff @(posedge clk) begin
    if (rst || clr) coarse <= '0;
    else            coarse <= coarse + 1'b1;
  end

  phase_sampler u_samp (
    .clk(clk), .clk_shift(clk_shift), .rst(rst), .din(sig_in), .win(win)
  );

  edge_finder u_find (
    .clk(clk), .rst(rst), .win(win), .hit(hit), .fine(fine)
  );

  record_holder #(.EVT_W(EVT_W), .CRS_W(CRS_W)) u_hold (
    .clk(clk), .rst(rst), .clr(clr), .hit(hit), .fine(fine),
    .coarse_now(coarse), .ready(rec_ready), .valid(rec_valid),
    .evt_out(rec_event), .stamp_out(rec_stamp), .ovf(rec_ovf)
  );
endmodule

module edge_stamper_chk #(
  parameter int unsigned EVT_W   = 16,
  parameter int unsigned STAMP_W = 34
) (
  input logic               clk,
  input logic               rst,
  input logic               hit,
  input logic               rec_valid,
  input logic               rec_ready,
  input logic [EVT_W-1:0]   rec_event,
  input logic [STAMP_W-1:0] rec_stamp,
  input logic               rec_ovf
);
  // R1: a detected edge with room always yields a presented record.
  assert_edge_loads_R1: assert property (@(posedge clk) disable iff (rst)
    hit && (!rec_valid || rec_ready) |=> rec_valid);

  // R5: a stalled record is held unchanged.
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_event) && $stable(rec_stamp));

  // R6: an edge into a full, stalled holder raises the loss flag.
  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (rst)
    hit && rec_valid && !rec_ready |=> rec_ovf);

  // R6: the loss flag is sticky.
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    rec_ovf |=> rec_ovf);

  // R3: with levels of at least one period, one window holds at most one edge.
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

bind edge_stamper edge_stamper_chk #(.EVT_W(EVT_W), .STAMP_W(STAMP_W)) u_chk (
  .clk(clk), .rst(rst), .hit(hit), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_event(rec_event), .rec_stamp(rec_stamp), .rec_ovf(rec_ovf)
);

// File: tb/sim_edge_stamper.sv
`timescale 1ns/1ps
module sim_edge_stamper;
  localparam int EW = 16;
  localparam int CW = 32;
  localparam int SW = CW + 2;
  // {code[7:6], high cycles[5:3], low cycles[2:0]}; code n puts the rise
  // 1 ns + n*2.5 ns after a main rising edge.
  localparam int NV = 12;
  localparam logic [7:0] VEC [0:NV-1] = '{
    8'b00_001_000, 8'b00_001_000, 8'b00_001_000, 8'b00_001_000,
    8'b01_010_010, 8'b10_011_001, 8'b11_010_011, 8'b00_100_100,
    8'b10_010_010, 8'b01_011_000, 8'b11_011_001, 8'b00_010_001
  };

  logic clk = 0, clk_sh = 0, rst = 1, clr = 0, sig = 0, rdy = 1;
  logic          valid, ovf;
  logic [EW-1:0] evt;
  logic [SW-1:0] stamp;

  edge_stamper #(.EVT_W(EW), .CRS_W(CW)) u0 (
    .clk(clk), .clk_shift(clk_sh), .rst(rst), .clr(clr), .sig_in(sig),
    .rec_ready(rdy), .rec_valid(valid), .rec_event(evt), .rec_stamp(stamp),
    .rec_ovf(ovf)
  );

  initial forever #5 clk = ~clk;
  initial begin #2.5; forever #5 clk_sh = ~clk_sh; end

  // Reference period index (R2, R7).
  logic [31:0] bcnt = 0;
  always @(posedge clk) if (rst || clr) bcnt <= 0; else bcnt <= bcnt + 1;

  logic [EW-1:0] xe [0:63];
  logic [SW-1:0] xs [0:63];
  int wr = 0, rd = 0, errs = 0, chks = 0;
  logic [EW-1:0] nev = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && valid && rdy) begin
      if (rd < wr) begin
        chk("R1 event index", 64'(evt), 64'(xe[rd]));
        chk("R2 R3 timestamp", 64'(stamp), 64'(xs[rd]));
        rd++;
      end else begin
        chk("R1 unexpected record", 64'd1, 64'd0);
      end
    end
  end

  task automatic pulse(input int code, input int hi, input int lo, input bit keep);
    logic [31:0] j, cj;
    logic [1:0] f;
    @(posedge clk); #1;
    j = bcnt;
    if (code > 0) #(2.5 * code);
    sig = 1;
    f  = (code == 3) ? 2'd0 : 2'(code + 1);
    cj = (code == 3) ? j + 1 : j;
    if (keep) begin
      xe[wr] = nev;
      xs[wr] = {cj, f};
      wr++;
    end
    nev++;
    repeat (hi) @(posedge clk);
    #1 sig = 0;
    repeat (lo) @(posedge clk);
  endtask

  task automatic drain;
    repeat (8) @(posedge clk);
  endtask

  logic [EW-1:0] hold_e;
  logic [SW-1:0] hold_s;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 valid in reset", 64'(valid), 64'd0);
    chk("R8 ovf in reset", 64'(ovf), 64'd0);
    @(posedge clk); #1 rst = 0;
    repeat (4) @(negedge clk);
    chk("R8 valid idle", 64'(valid), 64'd0);
    chk("R8 ovf idle", 64'(ovf), 64'd0);

    // Table: phases, widths, back-to-back edges (R1 R2 R3 R9).
    for (int v = 0; v < NV; v++)
      pulse(int'(VEC[v][7:6]), int'(VEC[v][5:3]), int'(VEC[v][2:0]), 1'b1);
    drain();
    chk("R9 all table records seen", 64'(rd), 64'(wr));

    // R4: record latency.
    fork
      pulse(0, 2, 2, 1'b1);
      begin
        @(posedge clk);
        repeat (3) @(negedge clk);
        chk("R4 valid not yet", 64'(valid), 64'd0);
        @(negedge clk);
        chk("R4 valid on third edge", 64'(valid), 64'd1);
      end
    join
    drain();

    // R5 / R6: stall, drop, gap in event index.
    @(posedge clk); #1 rdy = 0;
    pulse(1, 2, 2, 1'b1);
    @(negedge clk);
    chk("R5 record presented", 64'(valid), 64'd1);
    chk("R6 ovf before drop", 64'(ovf), 64'd0);
    hold_e = evt;
    hold_s = stamp;
    pulse(2, 2, 2, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 valid held", 64'(valid), 64'd1);
    chk("R5 event held", 64'(evt), 64'(hold_e));
    chk("R5 stamp held", 64'(stamp), 64'(hold_s));
    chk("R6 ovf set", 64'(ovf), 64'd1);
    @(posedge clk); #1 rdy = 1;
    pulse(0, 2, 2, 1'b1);
    drain();

    // R7: clear zeroes event index and coarse count.
    @(posedge clk); #1 clr = 1;
    @(posedge clk); #1 clr = 0;
    nev = 0;
    pulse(1, 2, 2, 1'b1);
    pulse(3, 2, 2, 1'b1);
    drain();
    chk("R6 ovf sticky after clear", 64'(ovf), 64'd1);
    chk("R7 R1 all records seen", 64'(rd), 64'(wr));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      chks++;
      errs++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule